// File: doc/BRIEF.md
# Reconfigurable Branch Target Cache

This block holds copies of the first few instructions found at recently taken branch targets. Its purpose is to hide the start-up latency of instruction memory. A lookup happens only when a new fetch sequence begins. The fetch unit presents the target address on the lookup port, and both ways are searched in that cycle. On a hit, the block streams the cached instructions one per cycle, beginning the cycle after the lookup, while the external fetch catches up. Instructions past the end of an entry always come from external memory. On a miss, the block claims the least recently used way at that index. It then records the instructions that return on the fill port and marks the entry valid only once all of them have arrived.

One mode input selects the geometry of the same storage. When it is low, each way has 32 entries of four instructions. When it is high, each way has 64 entries of two instructions. This input sets both the index field and the number of instructions per burst. Changing it, or pulsing the invalidate input, empties the cache in a single cycle.

Control is a three-state machine:
- `ST_IDLE` waits for a lookup. It moves to `ST_STREAM` on a hit and to `ST_FILL` on a miss.
- `ST_STREAM` presents one cached instruction per cycle. It returns to `ST_IDLE` after the last one.
- `ST_FILL` writes one instruction per accepted fill beat. It returns to `ST_IDLE` after the last beat and marks the entry valid in that same step.

Other transitions:
- A new lookup in any state restarts the machine as if it were in `ST_IDLE`. A fill that is abandoned this way stays invalid.
- A flush (invalidate or a mode change) forces `ST_IDLE` from any state, and a lookup in the flush cycle is dropped.

Top module: `branch_target_cache`

## Requirements
- R1: After reset, `hit_o` and `out_valid` are low, and every lookup misses until an entry has been filled.
- R2: With `short_mode` low, a missing lookup is followed by exactly four accepted fill beats. A later lookup of that address raises `out_valid` on the four cycles after the lookup, delivering the filled instructions in fill order, after which `out_valid` falls.
- R3: With `short_mode` high, an entry holds two instructions and a hit streams exactly two. The index is address bits [6:1], so addresses differing only in bit 1 occupy different entries.
- R4: `hit_o` is a one-cycle pulse in the cycle after a lookup that hits, coinciding with the first streamed instruction. After a miss, both `hit_o` and `out_valid` stay low.
- R5: With `short_mode` low, the index is address bits [6:2]. Every other address bit, including the within-entry offset bits, must match the stored target, so an address differing only in bit 0 misses.
- R6: Each index has two ways, so two different targets with the same index can both hit. At most one way ever matches a lookup, and way 0 would win a double match.
- R7: Each index keeps a single least-recently-used bit, updated by every hit and every allocation. A miss replaces the way not used most recently.
- R8: An entry becomes valid only when its last fill beat is accepted. A lookup that arrives during a fill abandons that entry, and a later lookup of the abandoned target misses.
- R9: A one-cycle pulse on `inval` makes every entry invalid and drops `out_valid` on the next cycle.
- R10: Any change of `short_mode` invalidates every entry in one cycle, and a lookup presented in that cycle is ignored.
- R11: Fill beats with `fill_valid` low are waited for rather than counted. Fill beats arriving while no fill is pending are ignored and do not alter any stored instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Start of a new fetch sequence at `lk_addr` |
| lk_addr | input | ADDR_W | Branch target instruction address (word granular) |
| hit_o | output | 1 | Pulse: the preceding lookup hit |
| out_valid | output | 1 | `out_insn` carries a cached instruction this cycle |
| out_insn | output | INSN_W | Cached instruction stream |
| fill_valid | input | 1 | Instruction bus beat is present |
| fill_insn | input | INSN_W | Instruction returned from memory |
| inval | input | 1 | Invalidate all entries |
| short_mode | input | 1 | 1: 64 two-instruction entries per way; 0: 32 four-instruction entries per way |

## Verification
A wrong valid bit or tag shows up as a wrong `hit_o` on the cycle right after the next lookup of that target. A lost or misplaced fill write shows up as a wrong `out_insn` in the matching slot of the stream that follows. Because each test instruction encodes its target address and position, a slot written at the wrong index or way is detected on the first hit that reads it. A stale least-recently-used bit only becomes visible one allocation later, as a miss on the target that should have survived. The scenarios therefore run hit, hit, miss, hit sequences on a single index and check both survivors and victims.

// File: rtl/btc_pkg.sv
package btc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STREAM = 2'd1,
        ST_FILL   = 2'd2
    } btc_state_e;

    localparam int NWAYS = 2;

endpackage

// File: rtl/btc_data.sv
module btc_data
    import btc_pkg::*;
#(
    parameter int INSN_W = 32,
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic              wr_way,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [INSN_W-1:0] wr_data,
    input  logic              rd_way,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [INSN_W-1:0] rd_data
);

    localparam int SLOTS = 1 << SLOT_W;

    logic [INSN_W-1:0] way_rd [NWAYS];

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [INSN_W-1:0] mem_q [SLOTS];

        always_ff @(posedge clk) begin
            if (we && (wr_way == 1'(w))) begin
                mem_q[wr_slot] <= wr_data;
            end
        end

        assign way_rd[w] = mem_q[rd_slot];
    end

    assign rd_data = rd_way ? way_rd[1] : way_rd[0];

endmodule

// File: rtl/btc_tags.sv
module btc_tags
    import btc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic              lk_hit,
    output logic              lk_hit_way,
    output logic              lk_lru_way,
    input  logic              alloc_en,
    input  logic              touch_en,
    input  logic              commit_en,
    input  logic              commit_way,
    input  logic [IDX_W-1:0]  commit_idx
);

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] lru_q;
    logic [ENTRIES-1:0] valid_q [NWAYS];
    logic [NWAYS-1:0]   match;

    for (genvar w = 0; w < NWAYS; w++) begin : g_way
        logic [ADDR_W-1:0] tag_q [ENTRIES];

        always_ff @(posedge clk) begin
            if (alloc_en && (lk_lru_way == 1'(w))) begin
                tag_q[lk_idx] <= lk_addr;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_q[w] <= '0;
            end else begin
                if (alloc_en && (lk_lru_way == 1'(w))) begin
                    valid_q[w][lk_idx] <= 1'b0;
                end
                if (commit_en && (commit_way == 1'(w))) begin
                    valid_q[w][commit_idx] <= 1'b1;
                end
            end
        end

        assign match[w] = valid_q[w][lk_idx] && (tag_q[lk_idx] == lk_addr);
    end

    // way 0 wins if both ways ever matched
    assign lk_hit     = |match;
    assign lk_hit_way = !match[0];
    assign lk_lru_way = lru_q[lk_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (alloc_en) begin
            lru_q[lk_idx] <= ~lk_lru_way;
        end else if (touch_en) begin
            lru_q[lk_idx] <= ~lk_hit_way;
        end
    end

    // R6: allocation never lets one target live in both ways
    p_one_way_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R10: a flush leaves no valid entry behind
    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((valid_q[0] == '0) && (valid_q[1] == '0)));

endmodule

// File: rtl/btc_ctrl.sv
module btc_ctrl
    import btc_pkg::*;
#(
    parameter int SLOT_W = 7,
    parameter int IDX_W  = 6,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_go,
    input  logic              lk_hit,
    input  logic              lk_hit_way,
    input  logic              lk_lru_way,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [SLOT_W-1:0] lk_base,
    input  logic [OFS_W-1:0]  last_pos,
    input  logic              fill_valid,
    output logic              alloc_en,
    output logic              touch_en,
    output logic              wr_en,
    output logic              commit_en,
    output logic              cur_way,
    output logic [IDX_W-1:0]  cur_idx,
    output logic [SLOT_W-1:0] slot,
    output logic              out_valid,
    output logic              hit_pulse
);

    btc_state_e        state_q, state_d;
    logic [OFS_W-1:0]  cnt_q, cnt_d;
    logic              way_q, way_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [SLOT_W-1:0] base_q, base_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            way_q   <= 1'b0;
            idx_q   <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            way_q   <= way_d;
            idx_q   <= idx_d;
            base_q  <= base_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        way_d   = way_q;
        idx_d   = idx_q;
        base_d  = base_q;
        if (flush) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (lk_go) begin
            state_d = lk_hit ? ST_STREAM : ST_FILL;
            cnt_d   = '0;
            way_d   = lk_hit ? lk_hit_way : lk_lru_way;
            idx_d   = lk_idx;
            base_d  = lk_base;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d = '0;
                end
                ST_STREAM: begin
                    if (cnt_q == last_pos) begin
                        state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_FILL: begin
                    if (fill_valid) begin
                        if (cnt_q == last_pos) begin
                            state_d = ST_IDLE;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        alloc_en  = lk_go && !lk_hit;
        touch_en  = lk_go && lk_hit;
        wr_en     = (state_q == ST_FILL) && fill_valid && !lk_go && !flush;
        commit_en = wr_en && (cnt_q == last_pos);
        out_valid = (state_q == ST_STREAM);
        hit_pulse = out_valid && (cnt_q == '0);
        cur_way   = way_q;
        cur_idx   = idx_q;
        slot      = base_q | SLOT_W'(cnt_q);
    end

    // R3: position counter never runs past the entry length
    p_pos_bound_r3: assert property (@(posedge clk) disable iff (!rst_n || flush)
        (state_q != ST_IDLE) |-> (cnt_q <= last_pos));

    // R2: an uninterrupted stream advances one slot per cycle
    p_stream_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (cnt_q != last_pos) && !lk_go && !flush)
        |=> (out_valid && (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
    import btc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int INSN_W     = 32,
    parameter int LONG_OFS_W = 2,
    parameter int LONG_IDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit_o,
    output logic              out_valid,
    output logic [INSN_W-1:0] out_insn,
    input  logic              fill_valid,
    input  logic [INSN_W-1:0] fill_insn,
    input  logic              inval,
    input  logic              short_mode
);

    localparam int SHORT_OFS_W = LONG_OFS_W - 1;
    localparam int IDX_W       = LONG_IDX_W + 1;
    localparam int SLOT_W      = LONG_OFS_W + LONG_IDX_W;
    localparam logic [LONG_OFS_W-1:0] LONG_LAST  = '1;
    localparam logic [LONG_OFS_W-1:0] SHORT_LAST = LONG_OFS_W'((1 << SHORT_OFS_W) - 1);

    logic                  mode_q;
    logic                  flush;
    logic                  lk_go;
    logic [IDX_W-1:0]      lk_idx;
    logic [SLOT_W-1:0]     lk_base;
    logic [LONG_OFS_W-1:0] last_pos;
    logic                  lk_hit, lk_hit_way, lk_lru_way;
    logic                  alloc_en, touch_en, wr_en, commit_en;
    logic                  cur_way;
    logic [IDX_W-1:0]      cur_idx;
    logic [SLOT_W-1:0]     slot;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
        end else begin
            mode_q <= short_mode;
        end
    end

    assign flush = inval || (short_mode != mode_q);
    assign lk_go = lk_valid && !flush;

    assign lk_idx = short_mode
        ? lk_addr[SLOT_W-1:SHORT_OFS_W]
        : {1'b0, lk_addr[SLOT_W-1:LONG_OFS_W]};
    assign lk_base = short_mode
        ? {lk_addr[SLOT_W-1:SHORT_OFS_W], {SHORT_OFS_W{1'b0}}}
        : {lk_addr[SLOT_W-1:LONG_OFS_W], {LONG_OFS_W{1'b0}}};
    assign last_pos = short_mode ? SHORT_LAST : LONG_LAST;

    btc_tags #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_addr    (lk_addr),
        .lk_idx     (lk_idx),
        .lk_hit     (lk_hit),
        .lk_hit_way (lk_hit_way),
        .lk_lru_way (lk_lru_way),
        .alloc_en   (alloc_en),
        .touch_en   (touch_en),
        .commit_en  (commit_en),
        .commit_way (cur_way),
        .commit_idx (cur_idx)
    );

    btc_ctrl #(
        .SLOT_W (SLOT_W),
        .IDX_W  (IDX_W),
        .OFS_W  (LONG_OFS_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .lk_go      (lk_go),
        .lk_hit     (lk_hit),
        .lk_hit_way (lk_hit_way),
        .lk_lru_way (lk_lru_way),
        .lk_idx     (lk_idx),
        .lk_base    (lk_base),
        .last_pos   (last_pos),
        .fill_valid (fill_valid),
        .alloc_en   (alloc_en),
        .touch_en   (touch_en),
        .wr_en      (wr_en),
        .commit_en  (commit_en),
        .cur_way    (cur_way),
        .cur_idx    (cur_idx),
        .slot       (slot),
        .out_valid  (out_valid),
        .hit_pulse  (hit_o)
    );

    btc_data #(
        .INSN_W (INSN_W),
        .SLOT_W (SLOT_W)
    ) u_data (
        .clk     (clk),
        .we      (wr_en),
        .wr_way  (cur_way),
        .wr_slot (slot),
        .wr_data (fill_insn),
        .rd_way  (cur_way),
        .rd_slot (slot),
        .rd_data (out_insn)
    );

    // R4: a hit pulse always carries the first cached instruction
    p_hit_with_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> out_valid);

    // R9: after any flush the stream output is silent
    p_flush_silences_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

endmodule

// File: tb/branch_target_cache_tb.sv
module branch_target_cache_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_addr = '0;
    logic        hit_o;
    logic        out_valid;
    logic [31:0] out_insn;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_insn = '0;
    logic        inval = 1'b0;
    logic        short_mode = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [15:0] A = 16'h0120;
    localparam logic [15:0] B = 16'h01A0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_target_cache u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .hit_o      (hit_o),
        .out_valid  (out_valid),
        .out_insn   (out_insn),
        .fill_valid (fill_valid),
        .fill_insn  (fill_insn),
        .inval      (inval),
        .short_mode (short_mode)
    );

    function automatic logic [31:0] pat(logic [15:0] a, int k);
        return {a, 8'h5A, 8'(k)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // lookup at one negedge; returns at the next, where hit_o is visible
    task automatic lookup(logic [15:0] a, bit exp_hit, string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, "hit_o", 32'(hit_o), 32'(exp_hit));
        if (!exp_hit) chk(req, "out_valid after miss", 32'(out_valid), 32'd0);
    endtask

    task automatic stream(logic [15:0] a, int n, string req);
        for (int k = 0; k < n; k++) begin
            chk(req, "out_valid in stream", 32'(out_valid), 32'd1);
            chk(req, "out_insn", out_insn, pat(a, k));
            @(negedge clk);
        end
        chk(req, "out_valid after stream", 32'(out_valid), 32'd0);
    endtask

    task automatic fill(logic [15:0] a, int n, bit gaps);
        for (int k = 0; k < n; k++) begin
            fill_valid = 1'b1;
            fill_insn  = pat(a, k);
            @(negedge clk);
            if (gaps) begin
                fill_valid = 1'b0;
                fill_insn  = 32'hBAD0_0000;
                @(negedge clk);
            end
        end
        fill_valid = 1'b0;
    endtask

    task automatic miss_fill(logic [15:0] a, int n, string req);
        lookup(a, 1'b0, req);
        fill(a, n, 1'b0);
    endtask

    task automatic hit_stream(logic [15:0] a, int n, string req);
        lookup(a, 1'b1, req);
        stream(a, n, req);
    endtask

    task automatic t_reset();
        chk("R1", "hit_o at reset", 32'(hit_o), 32'd0);
        chk("R1", "out_valid at reset", 32'(out_valid), 32'd0);
        lookup(16'h0777, 1'b0, "R1");
        fill(16'h0777, 4, 1'b0);
    endtask

    task automatic t_long_basic();
        miss_fill(A, 4, "R2");
        hit_stream(A, 4, "R2");
        hit_stream(A, 4, "R4");
    endtask

    task automatic t_ways_lru();
        miss_fill(A + 16'd1, 4, "R5");   // offset bit differs: miss
        hit_stream(A, 4, "R6");
        hit_stream(A + 16'd1, 4, "R6");
        hit_stream(A, 4, "R7");
        miss_fill(B, 4, "R7");           // evicts A+1
        hit_stream(B, 4, "R7");
        hit_stream(A, 4, "R7");
        miss_fill(A + 16'd1, 4, "R7");   // evicts B
        hit_stream(A, 4, "R7");
    endtask

    task automatic t_fill_gaps();
        @(negedge clk);
        fill_valid = 1'b1;
        fill_insn  = 32'hDEAD_0000;
        @(negedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        chk("R11", "out_valid idle fill", 32'(out_valid), 32'd0);
        hit_stream(A, 4, "R11");
        lookup(16'h0410, 1'b0, "R11");
        fill(16'h0410, 4, 1'b1);
        hit_stream(16'h0410, 4, "R11");
    endtask

    task automatic t_abort();
        lookup(16'h0300, 1'b0, "R8");
        fill(16'h0300, 2, 1'b0);
        miss_fill(16'h0344, 4, "R8");
        hit_stream(16'h0344, 4, "R8");
        miss_fill(16'h0300, 4, "R8");
        hit_stream(16'h0300, 4, "R8");
    endtask

    task automatic t_invalidate();
        @(negedge clk);
        inval = 1'b1;
        @(negedge clk);
        inval = 1'b0;
        chk("R9", "out_valid after inval", 32'(out_valid), 32'd0);
        miss_fill(A, 4, "R9");
        lookup(16'h0300, 1'b0, "R9");
        fill(16'h0300, 4, 1'b0);
    endtask

    task automatic t_short_mode();
        @(negedge clk);
        short_mode = 1'b1;
        lk_valid   = 1'b1;           // dropped: flush cycle
        lk_addr    = A;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R10", "out_valid in flush", 32'(out_valid), 32'd0);
        chk("R10", "hit_o in flush", 32'(hit_o), 32'd0);
        miss_fill(A, 2, "R10");
        hit_stream(A, 2, "R3");
        miss_fill(A + 16'd2, 2, "R3");
        miss_fill(B, 2, "R3");
        hit_stream(A, 2, "R3");
        hit_stream(A + 16'd2, 2, "R3");
        hit_stream(B, 2, "R3");
        @(negedge clk);
        short_mode = 1'b0;
        @(negedge clk);
        miss_fill(B, 4, "R10");
        hit_stream(B, 4, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_basic();
        t_ways_lru();
        t_fill_gaps();
        t_abort();
        t_invalidate();
        t_short_mode();
        repeat (2) @(negedge clk);
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

endmodule